// File: doc/BRIEF.md
# Extended-Address Flash Command Sequencer

This block turns host requests that carry a full 32-bit flash address into byte frames for a serial flash that decodes only three address bytes. The device holds the top address byte in a one-byte extended address register. Before each read, page program or erase, the sequencer makes sure that register holds bits 31:24 of the target. It keeps its own copy of the register with a valid flag and only rewrites the register when the copy is invalid or the high byte changes. It then issues the three-byte-address command.

The host side is a request port with a ready signal, a write-data stream for programs, a read-data stream and a one-cycle completion pulse with an error flag. The flash side is a byte-exchange handshake: the block raises `spi_req` with a byte on `spi_tx`, and the byte engine answers with a one-cycle `spi_ack` carrying the received byte and a failure flag. `spi_cs_n` frames each command. Erases are followed by status polling at a programmable interval, with a bounded number of polls.

Top module: `flash_xaddr_seq`

## Requirements
- R1: Operation codes on `req_op` are 0 read, 1 page program, 2 erase 4 KB, 3 erase 32 KB, 4 erase 64 KB, 5 read extended register. A read, program or erase command frame is the opcode (0x03, 0x02, 0x20, 0x52, 0xD8) followed by address bits 23:16, 15:8, 7:0 in that order.
- R2: A register update is a one-byte frame 0x06 followed by a two-byte frame 0xC5 then bits 31:24 of the request address.
- R3: The register update is sent only when the cached copy is invalid or differs from bits 31:24 of the request. Reset invalidates the copy, so the first addressed operation after reset always updates the register.
- R4: If any byte of the update's 0x06 or 0xC5 frame is acknowledged with `spi_err`, the copy becomes invalid, the request completes with `done_err` and no command frame is sent.
- R5: Programs and erases send a one-byte 0x06 frame right before the command frame; reads send none. `spi_cs_n` is high while idle and for at least one cycle between frames.
- R6: A program with a length of 0 or above 256 completes with `done_err` and produces no frame.
- R7: A program frame carries `req_len` bytes taken in order from the write stream; a read frame returns `req_len` bytes on the read stream in order.
- R8: After an erase, two-byte 0x05 frames are sent; when bit 0 of the second received byte is 0 the request completes without error.
- R9: Before every status frame `spi_cs_n` stays high for a wait set by `cfg_poll_short` for a 4 KB erase and by `cfg_poll_long` for the larger erases, the waits differing by exactly the difference of the two settings.
- R10: If `POLL_LIMIT` status reads all show bit 0 set, the request completes with `done_err`.
- R11: Operation 5 sends a two-byte frame 0xC8, 0x00, returns the second received byte on the read stream, and never updates the register.
- R12: While `spi_req` is high without `spi_ack`, the request and `spi_tx` stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_op | input | 3 | Operation code (R1) |
| req_addr | input | 32 | Full flash address |
| req_len | input | LEN_W | Byte count for read or program |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data available |
| wr_ready | output | 1 | Program data byte consumed |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | Returned byte strobe |
| done | output | 1 | Request complete pulse |
| done_err | output | 1 | Request failed, valid with done |
| cfg_poll_short | input | CW | Status wait for 4 KB erase |
| cfg_poll_long | input | CW | Status wait for 32/64 KB erase |
| spi_cs_n | output | 1 | Frame select, active low |
| spi_req | output | 1 | Byte exchange request |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | Byte exchanged |
| spi_rx | input | 8 | Byte received, valid with spi_ack |
| spi_err | input | 1 | Exchange failed, valid with spi_ack |

## Verification
The hardest state to reach is a failed register update followed by recovery: the byte engine must report a fault exactly on the 0xC5 frame, and the next request must then rewrite the register even when its high byte matches what the device still holds. The bench's flash model injects the fault on demand and tracks what the device register really holds apart from what the cache should believe, so a following read of the register and a read at the old high byte show whether the invalidation took effect. Random requests drawn from a small set of high bytes make cache hits and misses alternate, and the poll-limit and wait-length cases are driven directly by the model's busy count.

// File: rtl/flash_xaddr_pkg.sv
package flash_xaddr_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ER4K  = 3'd2,
    OP_ER32K = 3'd3,
    OP_ER64K = 3'd4,
    OP_RDX   = 3'd5
  } op_e;

  typedef enum logic [1:0] {F_WREN, F_XWR, F_CMD, F_RDSR} frame_e;
  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP, S_WAIT} state_e;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_XWR  = 8'hC5;
  localparam logic [7:0] OPC_XRD  = 8'hC8;
  localparam logic [7:0] OPC_RDSR = 8'h05;

  function automatic logic [7:0] cmd_opcode(input op_e o);
    case (o)
      OP_READ:  return 8'h03;
      OP_PROG:  return 8'h02;
      OP_ER4K:  return 8'h20;
      OP_ER32K: return 8'h52;
      OP_ER64K: return 8'hD8;
      default:  return OPC_XRD;
    endcase
  endfunction

  function automatic logic is_erase(input op_e o);
    return (o == OP_ER4K) || (o == OP_ER32K) || (o == OP_ER64K);
  endfunction

  function automatic logic needs_wren(input op_e o);
    return (o == OP_PROG) || is_erase(o);
  endfunction

endpackage

// File: rtl/xaddr_cache.sv
module xaddr_cache #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inv,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] probe,
  output logic         hit
);
  logic         valid;
  logic [W-1:0] val;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      val   <= '0;
    end else if (inv) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      val   <= load_val;
    end
  end

  assign hit = valid && (val == probe);
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int CW    = 16,
  parameter int LIMIT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          run,
  input  logic          poll_clr,
  input  logic          poll_inc,
  input  logic [CW-1:0] interval,
  output logic          expired,
  output logic          at_limit
);
  localparam int PW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic [PW-1:0] polls;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      polls <= '0;
    end else begin
      if (load)
        cnt <= interval;
      else if (run && cnt != '0)
        cnt <= cnt - 1'b1;
      if (poll_clr)
        polls <= '0;
      else if (poll_inc && !at_limit)
        polls <= polls + 1'b1;
    end
  end

  assign expired  = (cnt == '0);
  assign at_limit = (polls == PW'(LIMIT));
endmodule

// File: rtl/flash_xaddr_seq.sv
module flash_xaddr_seq
  import flash_xaddr_pkg::*;
#(
  parameter int LEN_W      = 9,
  parameter int MAX_PAGE   = 256,
  parameter int CW         = 16,
  parameter int POLL_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             done_err,
  input  logic [CW-1:0]    cfg_poll_short,
  input  logic [CW-1:0]    cfg_poll_long,
  output logic             spi_cs_n,
  output logic             spi_req,
  output logic [7:0]       spi_tx,
  input  logic             spi_ack,
  input  logic [7:0]       spi_rx,
  input  logic             spi_err
);
  localparam int IW  = LEN_W + 1;
  localparam int HDR = 4;

  state_e           state;
  frame_e           cur, nxt_cur;
  op_e              op_q, req_op_e;
  logic [31:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [IW-1:0]    idx, frame_len;
  logic             ferr, wip, xw_phase;
  logic             bad_len, need_x, last, is_data, rd_byte;
  logic             cache_hit, cache_inv, cache_load;
  logic             tmr_load, tmr_expired, poll_clr, poll_inc, poll_at_limit;
  logic             go_frame, go_wait, fin, fin_err;

  assign req_op_e  = op_e'(req_op);
  assign bad_len   = (req_op_e == OP_PROG) &&
                     ((req_len == '0) || (req_len > LEN_W'(MAX_PAGE)));
  assign need_x    = (req_op_e != OP_RDX) && !cache_hit;
  assign req_ready = (state == S_IDLE);
  assign spi_cs_n  = (state != S_FRAME);

  xaddr_cache #(.W(8)) i_cache (
    .clk(clk), .rst(rst), .inv(cache_inv), .load(cache_load),
    .load_val(addr_q[31:24]), .probe(req_addr[31:24]), .hit(cache_hit)
  );

  poll_timer #(.CW(CW), .LIMIT(POLL_LIMIT)) i_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .run(state == S_WAIT),
    .poll_clr(poll_clr), .poll_inc(poll_inc),
    .interval((op_q == OP_ER4K) ? cfg_poll_short : cfg_poll_long),
    .expired(tmr_expired), .at_limit(poll_at_limit)
  );

  assign poll_inc = (state == S_WAIT) && tmr_expired;

  // frame geometry
  always_comb begin
    unique case (cur)
      F_WREN:  frame_len = IW'(1);
      F_XWR,
      F_RDSR:  frame_len = IW'(2);
      default: begin
        if (op_q == OP_READ || op_q == OP_PROG) frame_len = IW'(HDR) + {1'b0, len_q};
        else if (op_q == OP_RDX)                frame_len = IW'(2);
        else                                    frame_len = IW'(HDR);
      end
    endcase
  end

  assign last     = (idx == frame_len - IW'(1));
  assign is_data  = (cur == F_CMD) && (op_q == OP_PROG) && (idx >= IW'(HDR));
  assign rd_byte  = (cur == F_CMD) &&
                    (((op_q == OP_READ) && (idx >= IW'(HDR))) ||
                     ((op_q == OP_RDX) && (idx == IW'(1))));
  assign spi_req  = (state == S_FRAME) && (!is_data || wr_valid);
  assign wr_ready = (state == S_FRAME) && is_data && spi_ack;

  // byte to send
  always_comb begin
    spi_tx = 8'h00;
    unique case (cur)
      F_WREN: spi_tx = OPC_WREN;
      F_XWR:  spi_tx = (idx == '0) ? OPC_XWR : addr_q[31:24];
      F_RDSR: spi_tx = (idx == '0) ? OPC_RDSR : 8'h00;
      default: begin
        if (idx == '0)             spi_tx = cmd_opcode(op_q);
        else if (op_q == OP_RDX)   spi_tx = 8'h00;
        else if (idx == IW'(1))    spi_tx = addr_q[23:16];
        else if (idx == IW'(2))    spi_tx = addr_q[15:8];
        else if (idx == IW'(3))    spi_tx = addr_q[7:0];
        else if (op_q == OP_PROG)  spi_tx = wr_data;
      end
    endcase
  end

  // decision between frames
  always_comb begin
    cache_inv = 1'b0; cache_load = 1'b0; go_frame = 1'b0; go_wait = 1'b0;
    fin = 1'b0; fin_err = 1'b0; nxt_cur = cur; poll_clr = 1'b0;
    if (state == S_GAP) begin
      unique case (cur)
        F_WREN: begin
          if (ferr) begin fin = 1'b1; fin_err = 1'b1; cache_inv = xw_phase; end
          else begin go_frame = 1'b1; nxt_cur = xw_phase ? F_XWR : F_CMD; end
        end
        F_XWR: begin
          if (ferr) begin fin = 1'b1; fin_err = 1'b1; cache_inv = 1'b1; end
          else begin
            cache_load = 1'b1; go_frame = 1'b1;
            nxt_cur = needs_wren(op_q) ? F_WREN : F_CMD;
          end
        end
        F_CMD: begin
          if (ferr)                  begin fin = 1'b1; fin_err = 1'b1; end
          else if (is_erase(op_q))   begin go_wait = 1'b1; poll_clr = 1'b1; end
          else                       fin = 1'b1;
        end
        default: begin
          if (ferr || (wip && poll_at_limit)) begin fin = 1'b1; fin_err = 1'b1; end
          else if (!wip)                      fin = 1'b1;
          else                                go_wait = 1'b1;
        end
      endcase
    end
  end
  assign tmr_load = go_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;  cur <= F_WREN;  op_q <= OP_READ;
      addr_q <= '0;     len_q <= '0;    idx <= '0;
      ferr <= 1'b0;     wip <= 1'b0;    xw_phase <= 1'b0;
      done <= 1'b0;     done_err <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          op_q <= req_op_e; addr_q <= req_addr; len_q <= req_len;
          idx <= '0; ferr <= 1'b0;
          if (bad_len) begin
            done <= 1'b1; done_err <= 1'b1;
          end else begin
            state    <= S_FRAME;
            xw_phase <= need_x;
            cur      <= (need_x || needs_wren(req_op_e)) ? F_WREN : F_CMD;
          end
        end
        S_FRAME: if (spi_ack) begin
          ferr <= ferr | spi_err;
          if (rd_byte) begin rd_valid <= 1'b1; rd_data <= spi_rx; end
          if (cur == F_RDSR && idx == IW'(1)) wip <= spi_rx[0];
          if (last) state <= S_GAP;
          else      idx   <= idx + 1'b1;
        end
        S_GAP: begin
          idx <= '0; ferr <= 1'b0; cur <= nxt_cur;
          if (cache_load) xw_phase <= 1'b0;
          if (fin) begin
            state <= S_IDLE; done <= 1'b1; done_err <= fin_err;
          end else if (go_frame) state <= S_FRAME;
          else if (go_wait)      state <= S_WAIT;
        end
        default: if (tmr_expired) begin
          state <= S_FRAME; cur <= F_RDSR;
        end
      endcase
    end
  end

  AST_CS_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (rst)
    (state == S_FRAME && spi_ack && last) |=> spi_cs_n); // R5
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && req_valid && bad_len) |=> (spi_cs_n && done && done_err)); // R6
  AST_XWR_FAIL_ABORT: assert property (@(posedge clk) disable iff (rst)
    (state == S_GAP && cur == F_XWR && ferr) |=> (done && done_err && spi_cs_n)); // R4
  AST_WIP_CLEAR_DONE: assert property (@(posedge clk) disable iff (rst)
    (state == S_FRAME && cur == F_RDSR && spi_ack && last && !spi_err && !ferr && !spi_rx[0])
      |-> ##2 (done && !done_err)); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx))); // R12
endmodule

// File: tb/test_flash_xaddr_seq.sv
`timescale 1ns/1ps
module test_flash_xaddr_seq;
  localparam int LIMIT = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [8:0]  req_len = '0;
  logic [7:0]  wr_data;
  logic        wr_ready, rd_valid, done, done_err;
  logic [7:0]  rd_data;
  logic [15:0] cfg_short = 16'd3, cfg_long = 16'd10;
  logic        spi_cs_n, spi_req, s_ack, s_err;
  logic [7:0]  spi_tx, s_rx;

  flash_xaddr_seq #(.POLL_LIMIT(LIMIT)) i_flash_xaddr_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_valid(1'b1), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .done_err(done_err),
    .cfg_poll_short(cfg_short), .cfg_poll_long(cfg_long),
    .spi_cs_n(spi_cs_n), .spi_req(spi_req), .spi_tx(spi_tx),
    .spi_ack(s_ack), .spi_rx(s_rx), .spi_err(s_err)
  );

  int checks = 0, fails = 0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'h5A;
  endfunction

  function automatic int exp_flen(input logic [7:0] opc, input int len);
    case (opc)
      8'h06: return 1;
      8'h02, 8'h03: return 4 + len;
      8'h20, 8'h52, 8'hD8: return 4;
      default: return 2;
    endcase
  endfunction

  // behavioural flash slave and logs
  int          fidx, nf, hi_cnt, rn, wcnt, busy, busy_cfg;
  bit          inj, prev_cs;
  logic [7:0]  cur_op, xreg;
  logic [23:0] cur_addr;
  logic [31:0] cmd_addr;
  logic [7:0]  fop [64];
  int          flen [64], fgap [64];
  logic [7:0]  rbuf [4096];
  logic [7:0]  pmem [256];

  assign wr_data = wcnt[7:0] ^ 8'hC3;

  always @(posedge clk) begin
    if (rst) begin
      s_ack <= 0; s_err <= 0; s_rx <= 0; fidx <= 0; prev_cs <= 1; nf <= 0;
      hi_cnt <= 0; xreg <= 0; busy <= 0; rn <= 0; wcnt <= 0; cur_op <= 0;
      cur_addr <= 0; cmd_addr <= 0;
    end else begin
      s_ack <= 0; s_err <= 0; prev_cs <= spi_cs_n;
      if (rd_valid) begin rbuf[rn & 4095] <= rd_data; rn <= rn + 1; end
      if (wr_ready) wcnt <= wcnt + 1;
      if (spi_cs_n) begin hi_cnt <= hi_cnt + 1; fidx <= 0; end
      if (!prev_cs && spi_cs_n) begin
        fop[nf & 63] <= cur_op; flen[nf & 63] <= fidx; nf <= nf + 1;
      end
      if (prev_cs && !spi_cs_n) begin fgap[nf & 63] <= hi_cnt; hi_cnt <= 0; end
      if (!spi_cs_n && spi_req && !s_ack) begin
        s_ack <= 1; s_rx <= 8'h00; fidx <= fidx + 1;
        if (fidx == 0) cur_op <= spi_tx;
        else begin
          if (fidx <= 3) cur_addr <= {cur_addr[15:0], spi_tx};
          if (fidx == 3) begin
            cmd_addr <= {xreg, cur_addr[15:0], spi_tx};
            if (cur_op == 8'h20 || cur_op == 8'h52 || cur_op == 8'hD8) busy <= busy_cfg;
          end
          case (cur_op)
            8'hC5: if (fidx == 1) begin if (inj) s_err <= 1; else xreg <= spi_tx; end
            8'h05: if (fidx == 1) begin
                     s_rx <= {7'b0, busy != 0};
                     if (busy != 0) busy <= busy - 1;
                   end
            8'hC8: if (fidx == 1) s_rx <= xreg;
            8'h03: if (fidx >= 4) s_rx <= pat({xreg, cur_addr + 24'(fidx - 4)});
            8'h02: if (fidx >= 4) pmem[(fidx - 4) & 255] <= spi_tx;
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model of cache and device register
  bit         m_valid = 0;
  logic [7:0] m_hi = 0, dev_x = 0;
  int         last_gap;

  task automatic run_op(input int op, input logic [31:0] addr, input int len,
                        input int busyn, input bit inject);
    logic [7:0] exp_op [16];
    int n_exp, f0, r0, w0, polls, first_poll;
    bit need_x, exp_err, bad, derr;
    string tg;
    busy_cfg = busyn; inj = inject;
    f0 = nf; r0 = rn; w0 = wcnt;
    @(negedge clk);
    req_valid = 1; req_op = op[2:0]; req_addr = addr; req_len = len[8:0];
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    derr = done_err;
    @(negedge clk);

    bad = (op == 1) && (len == 0 || len > 256);
    need_x = !bad && (op != 5) && !(m_valid && m_hi == addr[31:24]);
    n_exp = 0; exp_err = 0; first_poll = 0;
    tg = (op == 5) ? "R11" : (op >= 2) ? "R8" : "R7";
    if (bad) begin
      exp_err = 1; tg = "R6";
    end else begin
      if (need_x) begin
        exp_op[n_exp++] = 8'h06; exp_op[n_exp++] = 8'hC5;
        if (inject) begin exp_err = 1; m_valid = 0; tg = "R4"; end
        else begin m_valid = 1; m_hi = addr[31:24]; dev_x = addr[31:24]; end
      end
      if (!exp_err) begin
        if (op >= 1 && op <= 4) exp_op[n_exp++] = 8'h06;
        case (op)
          0: exp_op[n_exp++] = 8'h03;
          1: exp_op[n_exp++] = 8'h02;
          2: exp_op[n_exp++] = 8'h20;
          3: exp_op[n_exp++] = 8'h52;
          4: exp_op[n_exp++] = 8'hD8;
          default: exp_op[n_exp++] = 8'hC8;
        endcase
        if (op >= 2 && op <= 4) begin
          polls = (busyn + 1 > LIMIT) ? LIMIT : busyn + 1;
          if (busyn >= LIMIT) begin exp_err = 1; tg = "R10"; end
          first_poll = n_exp;
          for (int i = 0; i < polls; i++) exp_op[n_exp++] = 8'h05;
        end
      end
    end
    chk({tg, " done_err"}, derr, exp_err);
    chk({tg, " R5 frame count"}, nf - f0, n_exp);
    if (nf - f0 == n_exp) begin
      for (int i = 0; i < n_exp; i++) begin
        chk({tg, " R1 R2 R5 opcode"}, fop[(f0 + i) & 63], exp_op[i]);
        chk({tg, " R1 frame length"}, flen[(f0 + i) & 63], exp_flen(exp_op[i], len));
      end
      if (first_poll > 0) last_gap = fgap[(f0 + first_poll) & 63];
    end
    if (need_x) chk("R2 device register", xreg, dev_x);
    if (!exp_err && op <= 4) chk("R1 command address", cmd_addr, addr);
    if (!bad && !exp_err && op == 0) begin
      chk("R7 read count", rn - r0, len);
      for (int k = 0; k < len; k++)
        chk("R7 read data", rbuf[(r0 + k) & 4095], pat({addr[31:24], addr[23:0] + 24'(k)}));
    end
    if (!bad && !exp_err && op == 1) begin
      chk("R7 program count", wcnt - w0, len);
      for (int k = 0; k < len; k++)
        chk("R7 program data", pmem[k], 8'((w0 + k) & 255) ^ 8'hC3);
    end
    if (op == 5) begin
      chk("R11 read count", rn - r0, 1);
      chk("R11 register value", rbuf[r0 & 4095], dev_x);
    end
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int g1, g2, op, len, busyn;
    logic [7:0] hi;
    void'($urandom(32'd2024));
    busy_cfg = 0; inj = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    chk("R5 reset cs_n", spi_cs_n, 1);
    chk("R5 reset req", spi_req, 0);
    chk("R3 reset ready", req_ready, 1);
    chk("R3 reset done", done, 0);

    run_op(0, 32'h12_00_10_F0, 4, 0, 0);     // R3 first op writes register
    run_op(0, 32'h12_33_44_55, 3, 0, 0);     // R3 hit, no rewrite
    run_op(1, 32'h12_00_00_00, 0, 0, 0);     // R6 zero length
    run_op(1, 32'h12_00_00_00, 257, 0, 0);   // R6 too long
    run_op(1, 32'h12_00_01_00, 256, 0, 0);   // R7 full page
    run_op(1, 32'h12_00_02_00, 1, 0, 0);     // R7 single byte
    run_op(2, 32'h34_00_10_00, 2, 2, 0);     // R8 short wait
    g1 = last_gap;
    run_op(4, 32'h34_01_00_00, 0, 0, 0);     // R9 long wait
    g2 = last_gap;
    chk("R9 wait difference", g2 - g1, cfg_long - cfg_short);
    chk("R9 short wait at least setting", g1 >= cfg_short, 1);
    run_op(3, 32'h34_08_00_00, 0, 20, 0);    // R10 poll limit
    run_op(0, 32'h56_00_00_00, 2, 0, 1);     // R4 update fails
    run_op(5, 32'h00_00_00_00, 0, 0, 0);     // R11 device keeps old value
    run_op(0, 32'h34_00_00_08, 2, 0, 0);     // R4 cache invalid: rewrite
    run_op(5, 32'h00_00_00_00, 0, 0, 0);     // R11

    for (int n = 0; n < 40; n++) begin
      op = $urandom % 6;
      case ($urandom % 4)
        0: hi = 8'h00; 1: hi = 8'h01; 2: hi = 8'h7F; default: hi = 8'hFF;
      endcase
      len = (op == 0) ? $urandom % 9 : 1 + $urandom % 12;
      busyn = $urandom % 4;
      run_op(op, {hi, 24'($urandom)}, len, busyn, ($urandom % 8) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule